// File: doc/BRIEF.md
# Register Alias Table Renamer

This block sits at the rename stage of an out-of-order integer pipeline. It accepts at most one micro-op per cycle. It translates the two source and one destination architectural register numbers into physical register tags. The speculative alias table always names the newest physical version of each of the 16 architectural registers. A small per-tag reference counter tracks which of the 128 physical tags are still in use. The renamed micro-op appears on registered outputs one cycle after it is accepted. It carries the tag that the destination used to hold, which the retirement stage hands back later to release it.

Two kinds of micro-op need no execution and are resolved here. An exclusive-or or subtract of a register with itself yields zero whatever the operand holds. Its destination is pointed at physical tag 0, which is a permanent zero register, and no source dependency is reported. A register copy is eliminated by pointing the destination at the physical tag of its source. A shared tag is released only after every name that refers to it has been retired away.

The retirement port updates a committed copy of the table. A flush restores the speculative table from that copy and recomputes every reference count by walking the committed entries, one entry per cycle.

Top module: `rat_rename`

## Requirements
- R1: After reset every architectural register maps to tag 0, out_valid is low, in_ready is high, and the first allocated tag is 1.
- R2: A generic micro-op (opclass 0) is accepted when in_valid and in_ready are both high. One cycle later out_valid is high and out_elim is 0. out_src0 and out_src1 are the current tags of its sources. out_dst is the lowest-numbered free tag, and out_old is the tag the destination held before.
- R3: A source that names the same architectural register as the destination of the same micro-op receives the mapping from before that micro-op.
- R4: Opclass 1 (exclusive-or) or 2 (subtract) with equal source numbers reports sources 0 and 0, destination tag 0 and out_elim 1, and allocates nothing. With different source numbers it is renamed as in R2.
- R5: Opclass 3 (move, source 0 to destination) whose source tag has a count below 3 reports out_src0 as that tag, out_src1 as 0, out_dst equal to the source tag and out_elim 1, and allocates nothing.
- R6: A tag held by several architectural names through R5 becomes allocatable again only after all its references have been released by retirement.
- R7: A move whose source tag already has count 3 is renamed as in R2, with a fresh tag and out_elim 0.
- R8: When no tag is free, in_ready is low for micro-ops that need an allocation, and no output appears. Zeroing idioms and eliminated moves are still accepted.
- R9: A retirement (ret_valid) writes ret_new into the committed entry for ret_arch and releases one reference of ret_old. Tag 0 is never allocated.
- R10: A flush clears out_valid and holds in_ready low for the flush cycle and the following 16 cycles. Afterwards the speculative table equals the committed table, and only tags referenced by the committed table are in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Restore speculative table from committed table |
| in_valid | input | 1 | Micro-op offered |
| in_ready | output | 1 | Micro-op can be accepted this cycle |
| in_opc | input | 2 | Opclass: 0 generic, 1 xor, 2 sub, 3 move |
| in_src0 | input | 4 | First source architectural register |
| in_src1 | input | 4 | Second source architectural register |
| in_dst | input | 4 | Destination architectural register |
| out_valid | output | 1 | Renamed micro-op present |
| out_src0 | output | 7 | Physical tag of first source |
| out_src1 | output | 7 | Physical tag of second source |
| out_dst | output | 7 | Physical tag given to destination |
| out_old | output | 7 | Previous tag of destination, released at retirement |
| out_elim | output | 1 | Micro-op was resolved here and needs no execution |
| ret_valid | input | 1 | A micro-op retires |
| ret_arch | input | 4 | Its destination architectural register |
| ret_new | input | 7 | Tag now committed for that register |
| ret_old | input | 7 | Tag whose reference is released |

## Verification
The hardest state to reach from the ports is an exhausted free list, together with a tag whose counter is saturated. The stimulus first shares one tag among three names through back-to-back moves, so that a fourth move must fall back to allocation. It then issues generic micro-ops with no retirement until all 127 allocatable tags are in flight. At that point a stalled generic micro-op and accepted zeroing and move micro-ops are observed side by side. Release ordering of a shared tag is checked by retiring its owners one at a time and watching which tag the next allocation returns.

// File: rtl/rat_pkg.sv
// Package rat_pkg
// Shared types for the renamer: micro-op class codes and the recovery state.
package rat_pkg;

    // Opclass codes as they appear on in_opc.
    typedef enum logic [1:0] {
        OPC_ALU = 2'd0,
        OPC_XOR = 2'd1,
        OPC_SUB = 2'd2,
        OPC_MOV = 2'd3
    } opc_e;

    // Control state: normal renaming or walking the committed table.
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WALK = 1'b1
    } rat_state_e;

endpackage

// File: rtl/rat_map.sv
// Module rat_map
// Holds the speculative alias table and the committed alias table.
// Three combinational read ports serve the renamer. One more read port on
// the committed table serves the recovery walk.
// Assumes: the caller never asserts copy and cm_en in the same cycle.
module rat_map #(
    parameter int NA = 16,
    parameter int PW = 7,
    localparam int AW = $clog2(NA)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd0_arch,
    input  logic [AW-1:0] rd1_arch,
    input  logic [AW-1:0] rdd_arch,
    output logic [PW-1:0] rd0_tag,
    output logic [PW-1:0] rd1_tag,
    output logic [PW-1:0] rdd_tag,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_tag,
    input  logic          cm_en,
    input  logic [AW-1:0] cm_arch,
    input  logic [PW-1:0] cm_tag,
    input  logic          copy,
    input  logic [AW-1:0] walk_arch,
    output logic [PW-1:0] walk_tag
);

    logic [NA-1:0][PW-1:0] spec_q;
    logic [NA-1:0][PW-1:0] commit_q;

    // Speculative table: reset to zero, reload on copy, else install new mapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q <= '0;
        end else if (copy) begin
            spec_q <= commit_q;
        end else if (wr_en) begin
            spec_q[wr_arch] <= wr_tag;
        end
    end

    // Committed table: updated by retirement only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= '0;
        end else if (cm_en) begin
            commit_q[cm_arch] <= cm_tag;
        end
    end

    // Reads return state from before this cycle's write.
    assign rd0_tag  = spec_q[rd0_arch];
    assign rd1_tag  = spec_q[rd1_arch];
    assign rdd_tag  = spec_q[rdd_arch];
    assign walk_tag = commit_q[walk_arch];

    // R10: a copy leaves the speculative table equal to the committed one.
    a_r10_copy_exact: assert property (@(posedge clk) disable iff (!rst_n)
        copy |=> spec_q == $past(commit_q));

endmodule

// File: rtl/rat_refcnt.sv
// Module rat_refcnt
// Keeps a 2-bit reference count per physical tag. A tag is free when its
// count is zero. The lowest free tag above 0 is offered for allocation.
// Tag 0 is the permanent zero register and is never counted or offered.
// Assumes: one increment and one decrement port. The caller never
// increments a count of 3 and never decrements a count of 0.
module rat_refcnt #(
    parameter int NP = 128,
    localparam int PW = $clog2(NP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc_en,
    input  logic [PW-1:0] inc_tag,
    input  logic          dec_en,
    input  logic [PW-1:0] dec_tag,
    input  logic [PW-1:0] q_tag,
    output logic          q_sat,
    output logic          free_avail,
    output logic [PW-1:0] free_tag
);

    logic [1:0] cnt_q [NP];

    for (genvar t = 0; t < NP; t++) begin : g_cnt
        if (t == 0) begin : g_zero
            assign cnt_q[t] = 2'd0;
        end else begin : g_tag
            logic inc_hit;
            logic dec_hit;
            assign inc_hit = inc_en && (inc_tag == PW'(t));
            assign dec_hit = dec_en && (dec_tag == PW'(t));
            // Count update: clear, or step by the net of increment and decrement.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    cnt_q[t] <= 2'd0;
                end else if (inc_hit != dec_hit) begin
                    cnt_q[t] <= inc_hit ? cnt_q[t] + 2'd1 : cnt_q[t] - 2'd1;
                end
            end
        end
    end

    // Priority pick of the lowest-numbered free tag above 0.
    always_comb begin
        free_avail = 1'b0;
        free_tag   = '0;
        for (int t = NP - 1; t >= 1; t--) begin
            if (cnt_q[t] == 2'd0) begin
                free_avail = 1'b1;
                free_tag   = PW'(t);
            end
        end
    end

    assign q_sat = (cnt_q[q_tag] == 2'd3);

    // R6: a release never hits a tag that has no reference left.
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (dec_en && dec_tag != '0) |-> cnt_q[dec_tag] != 2'd0);

    // R7: a new reference never lands on a saturated count.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (inc_en && inc_tag != '0) |-> cnt_q[inc_tag] != 2'd3);

endmodule

// File: rtl/rat_rename.sv
// Module rat_rename
// One-wide register renamer. It detects zeroing idioms and register moves,
// allocates tags from rat_refcnt, and keeps the tables in rat_map. On a
// flush it restores the committed table and rebuilds the counts, one
// committed entry per cycle.
// Assumes: no retirement arrives while a flush or the walk is in progress.
// in_ready depends on the offered opclass and sources.
module rat_rename
    import rat_pkg::*;
#(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 128,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_opc,
    input  logic [AW-1:0] in_src0,
    input  logic [AW-1:0] in_src1,
    input  logic [AW-1:0] in_dst,
    output logic          out_valid,
    output logic [PW-1:0] out_src0,
    output logic [PW-1:0] out_src1,
    output logic [PW-1:0] out_dst,
    output logic [PW-1:0] out_old,
    output logic          out_elim,
    input  logic          ret_valid,
    input  logic [AW-1:0] ret_arch,
    input  logic [PW-1:0] ret_new,
    input  logic [PW-1:0] ret_old
);

    rat_state_e    state_q;
    logic [AW-1:0] walk_q;
    logic          running, walking;

    logic [PW-1:0] src0_tag, src1_tag, old_tag, walk_tag;
    logic          src0_sat, free_avail;
    logic [PW-1:0] free_tag;

    opc_e          opc;
    logic          is_zero, is_move, need_alloc, fire;
    logic [PW-1:0] dst_tag;
    logic          cm_en, dec_en, inc_en;
    logic [PW-1:0] inc_tag;

    assign running = (state_q == ST_RUN);
    assign walking = (state_q == ST_WALK);

    // Micro-op classification and acceptance.
    always_comb begin
        opc        = opc_e'(in_opc);
        is_zero    = (opc == OPC_XOR || opc == OPC_SUB) && (in_src0 == in_src1);
        is_move    = (opc == OPC_MOV) && !src0_sat;
        need_alloc = !is_zero && !is_move;
        in_ready   = running && !flush && (!need_alloc || free_avail);
        fire       = in_valid && in_ready;
        dst_tag    = is_zero ? '0 : (is_move ? src0_tag : free_tag);
    end

    // Count port steering: the walk and renaming never overlap.
    always_comb begin
        cm_en  = ret_valid && running && !flush;
        dec_en = cm_en && (ret_old != '0);
        if (walking) begin
            inc_en  = (walk_tag != '0);
            inc_tag = walk_tag;
        end else begin
            inc_en  = fire && (need_alloc || (is_move && src0_tag != '0));
            inc_tag = need_alloc ? free_tag : src0_tag;
        end
    end

    rat_map #(.NA(NUM_ARCH), .PW(PW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd0_arch  (in_src0),
        .rd1_arch  (in_src1),
        .rdd_arch  (in_dst),
        .rd0_tag   (src0_tag),
        .rd1_tag   (src1_tag),
        .rdd_tag   (old_tag),
        .wr_en     (fire),
        .wr_arch   (in_dst),
        .wr_tag    (dst_tag),
        .cm_en     (cm_en),
        .cm_arch   (ret_arch),
        .cm_tag    (ret_new),
        .copy      (flush),
        .walk_arch (walk_q),
        .walk_tag  (walk_tag)
    );

    rat_refcnt #(.NP(NUM_PHYS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (flush),
        .inc_en     (inc_en),
        .inc_tag    (inc_tag),
        .dec_en     (dec_en),
        .dec_tag    (ret_old),
        .q_tag      (src0_tag),
        .q_sat      (src0_sat),
        .free_avail (free_avail),
        .free_tag   (free_tag)
    );

    // Recovery sequencer: a flush starts a walk over every committed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            walk_q  <= '0;
        end else if (flush) begin
            state_q <= ST_WALK;
            walk_q  <= '0;
        end else if (walking) begin
            walk_q <= walk_q + AW'(1);
            if (walk_q == AW'(NUM_ARCH - 1)) begin
                state_q <= ST_RUN;
            end
        end
    end

    // Output register: renamed micro-op one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_valid <= 1'b0;
            out_src0  <= '0;
            out_src1  <= '0;
            out_dst   <= '0;
            out_old   <= '0;
            out_elim  <= 1'b0;
        end else begin
            out_valid <= fire;
            if (fire) begin
                out_src0 <= is_zero ? '0 : src0_tag;
                out_src1 <= (is_zero || is_move) ? '0 : src1_tag;
                out_dst  <= dst_tag;
                out_old  <= old_tag;
                out_elim <= !need_alloc;
            end
        end
    end

    // R2, R9: an executed micro-op never receives the zero tag.
    a_r2_dst_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_elim) |-> out_dst != '0);

    // R10: a flush empties the output stage on the next cycle.
    a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R4, R5: a resolved micro-op leaves the offered free tag unchanged.
    a_r5_elim_keeps_free: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !need_alloc && !cm_en) |=> $stable(free_tag) && $stable(free_avail));

    // R8: nothing is accepted while the table is being rebuilt.
    a_r8_walk_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        walking |-> !in_ready);

endmodule

// File: tb/sim_rat_rename.sv
module sim_rat_rename;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] in_opc = 2'd0;
    logic [3:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
    logic       out_valid;
    logic [6:0] out_src0, out_src1, out_dst, out_old;
    logic       out_elim;
    logic       ret_valid = 1'b0;
    logic [3:0] ret_arch = '0;
    logic [6:0] ret_new = '0, ret_old = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rat_rename u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_opc(in_opc),
        .in_src0(in_src0), .in_src1(in_src1), .in_dst(in_dst),
        .out_valid(out_valid), .out_src0(out_src0), .out_src1(out_src1),
        .out_dst(out_dst), .out_old(out_old), .out_elim(out_elim),
        .ret_valid(ret_valid), .ret_arch(ret_arch),
        .ret_new(ret_new), .ret_old(ret_old)
    );

    // Vector: opc, src0, src1, dst | exp src0, src1, dst, old, elim
    localparam int NV = 9;
    localparam logic [42:0] VEC [NV] = '{
        {2'd0, 4'd2, 4'd3, 4'd1, 7'd0, 7'd0, 7'd1, 7'd0, 1'b0}, // R1 R2 first tag 1
        {2'd0, 4'd1, 4'd1, 4'd2, 7'd1, 7'd1, 7'd2, 7'd0, 1'b0}, // R2
        {2'd0, 4'd1, 4'd2, 4'd1, 7'd1, 7'd2, 7'd3, 7'd1, 1'b0}, // R3 src equals dst
        {2'd1, 4'd5, 4'd5, 4'd3, 7'd0, 7'd0, 7'd0, 7'd0, 1'b1}, // R4 xor self
        {2'd0, 4'd3, 4'd0, 4'd4, 7'd0, 7'd0, 7'd4, 7'd0, 1'b0}, // R4 no tag used
        {2'd1, 4'd1, 4'd2, 4'd5, 7'd3, 7'd2, 7'd5, 7'd0, 1'b0}, // R4 xor distinct
        {2'd2, 4'd6, 4'd6, 4'd6, 7'd0, 7'd0, 7'd0, 7'd0, 1'b1}, // R4 sub self
        {2'd3, 4'd1, 4'd0, 4'd7, 7'd3, 7'd0, 7'd3, 7'd0, 1'b1}, // R5 move
        {2'd0, 4'd7, 4'd7, 4'd8, 7'd3, 7'd3, 7'd6, 7'd0, 1'b0}  // R5 consumer
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rename(input logic [1:0] op, input logic [3:0] s0,
                          input logic [3:0] s1, input logic [3:0] d);
        @(negedge clk);
        in_opc = op; in_src0 = s0; in_src1 = s1; in_dst = d;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic retire(input logic [3:0] a, input logic [6:0] n, input logic [6:0] o);
        @(negedge clk);
        ret_valid = 1'b1; ret_arch = a; ret_new = n; ret_old = o;
        @(posedge clk);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic chk_out(input string req, input int s0, input int s1,
                           input int d, input int o, input int e);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " src0"}, int'(out_src0), s0);
        chk({req, " src1"}, int'(out_src1), s1);
        chk({req, " dst"}, int'(out_dst), d);
        chk({req, " old"}, int'(out_old), o);
        chk({req, " elim"}, int'(out_elim), e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);

        // Vector walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            rename(VEC[i][42:41], VEC[i][40:37], VEC[i][36:33], VEC[i][32:29]);
            chk_out($sformatf("R2 vec%0d", i), int'(VEC[i][28:22]), int'(VEC[i][21:15]),
                    int'(VEC[i][14:8]), int'(VEC[i][7:1]), int'(VEC[i][0]));
        end

        // R9: retiring the old tag 1 makes it allocatable again
        retire(4'd1, 7'd3, 7'd1);
        rename(2'd0, 4'd0, 4'd0, 4'd1);
        chk_out("R9 reuse", 0, 0, 1, 3, 0);
        // R6: tag 3 still held by arch 7 after one release
        retire(4'd1, 7'd1, 7'd3);
        rename(2'd0, 4'd0, 4'd0, 4'd9);
        chk_out("R6 shared held", 0, 0, 7, 0, 0);
        rename(2'd0, 4'd0, 4'd0, 4'd7);
        chk_out("R6 overwrite", 0, 0, 8, 3, 0);
        retire(4'd7, 7'd8, 7'd3);
        rename(2'd0, 4'd0, 4'd0, 4'd10);
        chk_out("R6 released", 0, 0, 3, 0, 0);

        // R7: third share of tag 2 saturates, fourth falls back
        rename(2'd3, 4'd2, 4'd0, 4'd11);
        chk_out("R7 move a", 2, 0, 2, 0, 1);
        rename(2'd3, 4'd2, 4'd0, 4'd12);
        chk_out("R7 move b", 2, 0, 2, 0, 1);
        rename(2'd3, 4'd2, 4'd0, 4'd13);
        chk_out("R7 saturated", 2, 0, 9, 0, 0);

        // R8: use up tags 10..127
        for (int i = 0; i < 118; i++) rename(2'd0, 4'd0, 4'd0, 4'd14);
        chk("R8 last tag", int'(out_dst), 127);
        @(negedge clk);
        in_opc = 2'd0; in_src0 = 4'd0; in_src1 = 4'd1; in_dst = 4'd14;
        in_valid = 1'b1;
        #1;
        chk("R8 stall ready", int'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 no output", int'(out_valid), 0);
        rename(2'd1, 4'd3, 4'd3, 4'd0);
        chk_out("R8 zero when empty", 0, 0, 0, 0, 1);
        rename(2'd3, 4'd4, 4'd0, 4'd15);
        chk_out("R8 move when empty", 4, 0, 4, 0, 1);

        // R10: flush restores committed table (arch1->1, arch7->8)
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk("R10 ready in flush", int'(in_ready), 0);
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        chk("R10 out_valid", int'(out_valid), 0);
        begin
            int lowc = 0;
            while (!in_ready && lowc < 100) begin
                lowc++;
                @(negedge clk);
            end
            chk("R10 walk cycles", lowc, 16);
        end
        rename(2'd0, 4'd1, 4'd7, 4'd2);
        chk_out("R10 restored", 1, 8, 2, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule